// File: doc/BRIEF.md
# Seeded LFSR Pseudo-Random Generator

This block is a Fibonacci-style linear feedback shift register with a width set by a parameter. On each clock where stepping is enabled it moves its state one place toward the most significant bit. The new bit 0 is the XOR of the state bits that a run-time tap mask selects. Because the mask is an input and not a constant, one instance can run a maximal polynomial or a deliberately short one without being rebuilt.

A seed can be loaded at any time. The loaded value is also kept as an anchor. A one-cycle wrap pulse marks each step that brings the state back to that anchor, so the distance between pulses is the period of the current polynomial. The register can never enter the all-zero state, where it would stay forever. A zero seed, and any step that would produce zero, are both replaced by the default value 1.

Top module: `lfsr_prng`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `state_out` is 1 and `wrap_pulse` is 0.
- R2: A step (`step_en` high, `seed_load` low) sets the next state to `{state[W-2:0], fb}`. Here `fb` is the XOR of every `state[i]` whose `tap_mask[i]` is 1. For W=3 the polynomial x^3+x^2+1 is `tap_mask` = 3'b110.
- R3: With `step_en` and `seed_load` both low, `state_out` keeps its value and `wrap_pulse` is 0.
- R4: When `seed_load` is high, `state_out` takes `seed_in` on the next clock and `wrap_pulse` is 0, even if `step_en` is high in the same cycle. The loaded value becomes the anchor.
- R5: Loading a seed of zero gives a state and anchor of 1.
- R6: A step whose result would be zero sets the state to 1 instead. With W=3, mask 3'b010 and state 3'b100, the next state is 3'b001.
- R7: `wrap_pulse` is high in exactly the cycle in which a step has made `state_out` equal to the anchor, and low in every other cycle.
- R8: For W=3 with mask 3'b110 and seed 1, the register visits 7 distinct non-zero values, and the wrap pulse appears on the 7th step.
- R9: For W=3 with the non-maximal mask 3'b111 and seed 1, the wrap pulse appears on the 4th step.
- R10: Loading the same seed again with the same mask reproduces the same output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the register one step |
| seed_load | input | 1 | Load `seed_in` as state and anchor (overrides step) |
| seed_in | input | W | Seed value, zero replaced by 1 |
| tap_mask | input | W | Bit i set includes state bit i in the feedback XOR |
| state_out | output | W | Current register state |
| wrap_pulse | output | 1 | One-cycle mark of return to the anchor |

## Verification
A wrong feedback bit shows on `state_out` bit 0 one clock after the faulty step. From the next step on, the whole sequence no longer matches the model. A lost or corrupted anchor makes the wrap pulse appear at the wrong step count, or not at all, within one period. The period checks for the maximal and the non-maximal mask find such a fault within seven steps. A failure of the zero guard leaves the register stuck at zero, and every later sample shows it.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } lfsr_op_e;
endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
  parameter int W = 3,
  parameter logic [W-1:0] DEF_SEED = 1
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] mask,
  output logic [W-1:0] nxt
);
  logic [W-1:0] tapped;
  logic         fb;
  logic [W-1:0] raw;

  // one AND per tap position, reduced into the feedback bit
  for (genvar i = 0; i < W; i++) begin : g_tap
    assign tapped[i] = cur[i] & mask[i];
  end

  assign fb  = ^tapped;
  assign raw = {cur[W-2:0], fb};

  // lock-up guard: a zero result is replaced by the default seed
  always_comb begin
    nxt = raw;
    if (raw == '0) nxt = DEF_SEED;
  end
endmodule

// File: rtl/lfsr_regs.sv
module lfsr_regs
  import lfsr_pkg::*;
#(
  parameter int W = 3,
  parameter logic [W-1:0] DEF_SEED = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  lfsr_op_e      op,
  input  logic [W-1:0]  seed_in,
  input  logic [W-1:0]  nxt,
  output logic [W-1:0]  state_q,
  output logic [W-1:0]  anchor_q
);
  logic [W-1:0] seed_eff;
  assign seed_eff = (seed_in == '0) ? DEF_SEED : seed_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= DEF_SEED;
      anchor_q <= DEF_SEED;
    end else begin
      unique case (op)
        OP_LOAD: begin
          state_q  <= seed_eff;
          anchor_q <= seed_eff;
        end
        OP_STEP: state_q <= nxt;
        default: ;
      endcase
    end
  end

  assert_never_zero_R6: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> $stable(state_q));

  assert_load_seed_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD && seed_in != '0) |=> state_q == $past(seed_in));

  assert_zero_seed_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD && seed_in == '0) |=> state_q == DEF_SEED);

  assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
    op == OP_STEP |=> state_q[W-1:1] == $past(state_q[W-2:0]));
endmodule

// File: rtl/lfsr_wrap.sv
module lfsr_wrap
  import lfsr_pkg::*;
#(
  parameter int W = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  lfsr_op_e      op,
  input  logic [W-1:0]  nxt,
  input  logic [W-1:0]  anchor_q,
  input  logic [W-1:0]  state_q,
  output logic          wrap_q
);
  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= (op == OP_STEP) && (nxt == anchor_q);
  end

  assert_wrap_match_R7: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> state_q == anchor_q);

  assert_wrap_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    op != OP_STEP |=> !wrap_q);
endmodule

// File: rtl/lfsr_prng.sv
module lfsr_prng
  import lfsr_pkg::*;
#(
  parameter int W = 3,
  parameter logic [W-1:0] DEF_SEED = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          seed_load,
  input  logic [W-1:0]  seed_in,
  input  logic [W-1:0]  tap_mask,
  output logic [W-1:0]  state_out,
  output logic          wrap_pulse
);
  lfsr_op_e     op;
  logic [W-1:0] nxt;
  logic [W-1:0] state_q;
  logic [W-1:0] anchor_q;

  // load outranks step
  always_comb begin
    if (seed_load)    op = OP_LOAD;
    else if (step_en) op = OP_STEP;
    else              op = OP_HOLD;
  end

  lfsr_next #(.W(W), .DEF_SEED(DEF_SEED)) next_i (
    .cur (state_q),
    .mask(tap_mask),
    .nxt (nxt)
  );

  lfsr_regs #(.W(W), .DEF_SEED(DEF_SEED)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .seed_in (seed_in),
    .nxt     (nxt),
    .state_q (state_q),
    .anchor_q(anchor_q)
  );

  lfsr_wrap #(.W(W)) wrap_i (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .nxt     (nxt),
    .anchor_q(anchor_q),
    .state_q (state_q),
    .wrap_q  (wrap_pulse)
  );

  assign state_out = state_q;
endmodule

// File: tb/lfsr_prng_tb_top.sv
module lfsr_prng_tb_top;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         step_en = 1'b0;
  logic         seed_load = 1'b0;
  logic [W-1:0] seed_in = '0;
  logic [W-1:0] tap_mask = 3'b110;
  logic [W-1:0] state_out;
  logic         wrap_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lfsr_prng #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
    .seed_in(seed_in), .tap_mask(tap_mask),
    .state_out(state_out), .wrap_pulse(wrap_pulse)
  );

  // vector: {load, seed[2:0], en, mask[2:0], exp_state[2:0], exp_wrap}
  localparam logic [11:0] VEC [0:9] = '{
    12'h962, 12'h0E4, 12'h0EA, 12'h0E6, 12'h0EE,
    12'h0EC, 12'h0E8, 12'h0E3, 12'h0E4, 12'h064
  };

  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r;
    r = {s[W-2:0], ^(s & m)};
    if (r == '0) r = 1;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ld, input logic [W-1:0] sd, input logic en,
                     input logic [W-1:0] m);
    seed_load = ld; seed_in = sd; step_en = en; tap_mask = m;
    @(negedge clk);
  endtask

  task automatic period(input string req, input logic [W-1:0] m, input int exp_len);
    logic [W-1:0] e;
    int len;
    len = 0;
    cyc(1'b1, 3'b001, 1'b0, m);
    e = 3'b001;
    for (int k = 1; k <= 20; k++) begin
      cyc(1'b0, '0, 1'b1, m);
      e = model(e, m);
      chk({req, " state"}, int'(state_out), int'(e));
      if (wrap_pulse) begin
        len = k;
        break;
      end
    end
    chk({req, " period"}, len, exp_len);
  endtask

  initial begin
    logic [W-1:0] first [10];
    repeat (3) @(negedge clk);
    chk("R1 reset state", int'(state_out), 1);
    chk("R1 reset wrap", int'(wrap_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 state after reset", int'(state_out), 1);

    // table walk: R2 stepping, R7 wrap timing, R3 hold
    for (int i = 0; i < 10; i++) begin
      cyc(VEC[i][11], VEC[i][10:8], VEC[i][7], VEC[i][6:4]);
      chk("R2/R3/R4 table state", int'(state_out), int'(VEC[i][3:1]));
      chk("R7 table wrap", int'(wrap_pulse), int'(VEC[i][0]));
    end

    // R3: several idle cycles keep the state
    cyc(1'b0, 3'b111, 1'b0, 3'b111);
    cyc(1'b0, 3'b111, 1'b0, 3'b111);
    chk("R3 hold", int'(state_out), 2);

    // R5: zero seed becomes 1
    cyc(1'b1, 3'b000, 1'b0, 3'b110);
    chk("R5 zero seed", int'(state_out), 1);

    // R4: load wins over step
    cyc(1'b1, 3'b101, 1'b1, 3'b110);
    chk("R4 load priority", int'(state_out), 5);
    chk("R4 no wrap on load", int'(wrap_pulse), 0);

    // R6: step to zero replaced by 1
    cyc(1'b1, 3'b100, 1'b0, 3'b010);
    cyc(1'b0, 3'b000, 1'b1, 3'b010);
    chk("R6 zero guard", int'(state_out), 1);

    // R2: pure rotation mask
    cyc(1'b1, 3'b001, 1'b0, 3'b100);
    cyc(1'b0, 3'b000, 1'b1, 3'b100);
    chk("R2 rotate mask", int'(state_out), 2);

    period("R8 maximal", 3'b110, 7);
    period("R9 non-maximal", 3'b111, 4);

    // R10: same seed, same stream
    cyc(1'b1, 3'b011, 1'b0, 3'b110);
    for (int k = 0; k < 10; k++) begin
      cyc(1'b0, '0, 1'b1, 3'b110);
      first[k] = state_out;
    end
    cyc(1'b1, 3'b011, 1'b0, 3'b110);
    for (int k = 0; k < 10; k++) begin
      cyc(1'b0, '0, 1'b1, 3'b110);
      chk("R10 repeat stream", int'(state_out), int'(first[k]));
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule